// File: doc/BRIEF.md
# Three-Wide Integer Register Renamer

This block maps the logical sources of up to three micro-ops per clock onto physical locations, for a machine with eight integer architectural registers. Each physical location is either the committed retirement register file or one slot of a 40-entry reorder buffer. The renamer keeps one table entry per logical register, holding a "committed" flag and the slot pointer of the newest in-flight producer. The allocator supplies a destination slot for each op that writes a register. Each renamed group yields one physical source per operand slot, one cycle later.

Ops within a group are in program order. When an earlier op of the group writes a register that a later op reads, the later op takes that pointer directly instead of the stale table value. Retirement of a slot marks as committed only those table entries that still name it. A flush returns every entry to the committed file. Narrow (8- or 16-bit) writes are tracked so that a later full-width read of a register still produced by an unretired narrow write raises a partial-register stall flag.

Top module: `rat_rename`

## Requirements
- R1: The valid bits and physical sources of a group presented in cycle N appear in cycle N+1, with `out_valid` equal to the presented `in_valid`, unless flush or stall was high in cycle N. Op i uses bits [i*3 +: 3] of the logical-register fields, bits [i*6 +: 6] of `in_dst_ptr`, bits [i*7 +: 7] of each `out_psrc` bus, and bit 2*i+s of `in_wide` for its source s.
- R2: A physical source is 7 bits: bit 6 set with bits 5:0 zero means the committed register file; bit 6 clear means reorder-buffer slot bits 5:0. With no earlier writer in the group, a source returns the table state as it stood before the current clock edge.
- R3: A source whose register is written by an earlier valid op of the same group takes the pointer of the nearest such earlier op (bit 6 clear); an op never overrides its own sources.
- R4: When several ops of one group write the same register, the youngest one's pointer is kept in the table.
- R5: A retirement marks committed every table entry that is uncommitted and holds the retiring pointer; entries naming another pointer are untouched. It is visible to groups presented after the retirement cycle, and a rename of the same register in the retirement cycle takes precedence.
- R6: A flush sets every table entry to the committed file, discards the group presented with it (no table write, `out_valid` zero and stall flag low next cycle).
- R7: While `stall_in` is high the group presented makes no table write and produces `out_valid` zero next cycle; retirement still takes effect.
- R8: `out_partial_stall` is set one cycle after a group in which a valid op reads a register with its wide bit set while that register's current producer, from an earlier op of the group or an uncommitted table entry, was a narrow write. Retirement of that producer, a flush, or a full-width rewrite removes the condition.
- R9: After reset every entry refers to the committed file, and all outputs are zero.
- R10: An op with `in_valid` low neither writes the table, nor overrides later sources, nor raises the stall flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Op present, one bit per op |
| in_src0 | input | 9 | First logical source per op |
| in_src1 | input | 9 | Second logical source per op |
| in_wide | input | 6 | Source reads the full 32-bit register |
| in_dst_valid | input | 3 | Op writes a logical register |
| in_dst | input | 9 | Logical destination per op |
| in_dst_narrow | input | 3 | Destination write is 8 or 16 bits |
| in_dst_ptr | input | 18 | Reorder-buffer slot from the allocator per op |
| ret_valid | input | 1 | A reorder-buffer slot retires |
| ret_ptr | input | 6 | Retiring slot |
| flush | input | 1 | Mispredict or exception recovery |
| stall_in | input | 1 | Hold renaming this cycle |
| out_valid | output | 3 | Renamed op valid |
| out_psrc0 | output | 21 | Physical first source per op |
| out_psrc1 | output | 21 | Physical second source per op |
| out_partial_stall | output | 1 | Full read after unretired narrow write |

## Verification
Retirement and renaming can hit the same table entry in one cycle, and a flush can arrive together with a group that would otherwise write the table. Both are provoked directly: a slot retires while a new writer of its register is renamed, and a flush or stall is raised alongside a writing group, with a later read revealing which action won. A behavioural table model in the bench predicts every output each cycle, through directed cases and a long random run that draws retirement pointers from the live slot range so stale and current matches both occur.

// File: rtl/rat_rename.sv
module rat_rename #(
  parameter int NOPS      = 3,
  parameter int NREG      = 8,
  parameter int ROB_DEPTH = 40,
  localparam int AW = $clog2(NREG),
  localparam int PW = $clog2(ROB_DEPTH),
  localparam int SW = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NOPS-1:0]   in_valid,
  input  logic [NOPS*AW-1:0] in_src0,
  input  logic [NOPS*AW-1:0] in_src1,
  input  logic [NOPS*2-1:0] in_wide,
  input  logic [NOPS-1:0]   in_dst_valid,
  input  logic [NOPS*AW-1:0] in_dst,
  input  logic [NOPS-1:0]   in_dst_narrow,
  input  logic [NOPS*PW-1:0] in_dst_ptr,
  input  logic              ret_valid,
  input  logic [PW-1:0]     ret_ptr,
  input  logic              flush,
  input  logic              stall_in,
  output logic [NOPS-1:0]   out_valid,
  output logic [NOPS*SW-1:0] out_psrc0,
  output logic [NOPS*SW-1:0] out_psrc1,
  output logic              out_partial_stall
);

  logic [NREG-1:0] t_rrf;
  logic [NREG-1:0] t_narrow;
  logic [PW-1:0]   t_ptr [NREG];

  logic [NOPS*SW-1:0] nxt_ps0, nxt_ps1;
  logic               nxt_pstall;
  wire                quiet = flush | stall_in;

  always_comb begin
    nxt_ps0    = '0;
    nxt_ps1    = '0;
    nxt_pstall = 1'b0;
    for (int i = 0; i < NOPS; i++) begin
      for (int s = 0; s < 2; s++) begin
        logic [AW-1:0] lr;
        logic          rrf;
        logic [PW-1:0] p;
        logic          nar;
        logic [SW-1:0] ps;
        lr  = (s == 0) ? in_src0[i*AW +: AW] : in_src1[i*AW +: AW];
        rrf = t_rrf[lr];
        p   = t_ptr[lr];
        nar = t_narrow[lr] & ~t_rrf[lr];
        for (int j = 0; j < i; j++) begin
          if (in_valid[j] && in_dst_valid[j] && in_dst[j*AW +: AW] == lr) begin
            rrf = 1'b0;
            p   = in_dst_ptr[j*PW +: PW];
            nar = in_dst_narrow[j];
          end
        end
        ps = rrf ? {1'b1, {PW{1'b0}}} : {1'b0, p};
        if (s == 0) nxt_ps0[i*SW +: SW] = ps;
        else        nxt_ps1[i*SW +: SW] = ps;
        if (in_valid[i] && in_wide[i*2+s] && nar) nxt_pstall = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_rrf    <= '1;
      t_narrow <= '0;
      for (int r = 0; r < NREG; r++) t_ptr[r] <= '0;
    end else if (flush) begin
      t_rrf    <= '1;
      t_narrow <= '0;
    end else begin
      if (ret_valid) begin
        for (int r = 0; r < NREG; r++) begin
          if (!t_rrf[r] && t_ptr[r] == ret_ptr) begin
            t_rrf[r]    <= 1'b1;
            t_narrow[r] <= 1'b0;
          end
        end
      end
      if (!stall_in) begin
        for (int i = 0; i < NOPS; i++) begin
          if (in_valid[i] && in_dst_valid[i]) begin
            t_rrf[in_dst[i*AW +: AW]]    <= 1'b0;
            t_ptr[in_dst[i*AW +: AW]]    <= in_dst_ptr[i*PW +: PW];
            t_narrow[in_dst[i*AW +: AW]] <= in_dst_narrow[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid         <= '0;
      out_psrc0         <= '0;
      out_psrc1         <= '0;
      out_partial_stall <= 1'b0;
    end else begin
      out_valid         <= quiet ? '0 : in_valid;
      out_psrc0         <= nxt_ps0;
      out_psrc1         <= nxt_ps1;
      out_partial_stall <= quiet ? 1'b0 : nxt_pstall;
    end
  end

endmodule

// File: rtl/rat_rename_chk.sv
module rat_rename_chk #(
  parameter int NOPS      = 3,
  parameter int NREG      = 8,
  parameter int ROB_DEPTH = 40,
  localparam int AW = $clog2(NREG),
  localparam int PW = $clog2(ROB_DEPTH),
  localparam int SW = PW + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NOPS-1:0]    in_valid,
  input logic [NOPS*AW-1:0] in_src0,
  input logic [NOPS-1:0]    in_dst_valid,
  input logic [NOPS*AW-1:0] in_dst,
  input logic [NOPS*PW-1:0] in_dst_ptr,
  input logic               flush,
  input logic               stall_in,
  input logic [NOPS-1:0]    out_valid,
  input logic [NOPS*SW-1:0] out_psrc0,
  input logic               out_partial_stall
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall_in) |=> out_valid == $past(in_valid)); // R1

  AST_GROUP_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall_in && in_valid[0] && in_valid[1] && in_dst_valid[0]
     && in_src0[AW +: AW] == in_dst[0 +: AW])
    |=> out_psrc0[SW +: SW] == {1'b0, $past(in_dst_ptr[0 +: PW])}); // R3

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (out_valid == '0 && !out_partial_stall)); // R6

  AST_FLUSH_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && !flush && !stall_in && in_valid[0])
    |=> out_psrc0[0 +: SW] == {1'b1, {PW{1'b0}}}); // R6

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_in && !flush) |=> out_valid == '0); // R7

  AST_PSTALL_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    out_partial_stall |-> out_valid != '0); // R8

endmodule

bind rat_rename rat_rename_chk #(.NOPS(NOPS), .NREG(NREG), .ROB_DEPTH(ROB_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src0(in_src0),
  .in_dst_valid(in_dst_valid), .in_dst(in_dst), .in_dst_ptr(in_dst_ptr),
  .flush(flush), .stall_in(stall_in), .out_valid(out_valid),
  .out_psrc0(out_psrc0), .out_partial_stall(out_partial_stall)
);

// File: tb/rat_rename_tb.sv
`timescale 1ns/1ps
module rat_rename_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  in_valid, in_dst_valid, in_dst_narrow;
  logic [8:0]  in_src0, in_src1, in_dst;
  logic [5:0]  in_wide;
  logic [17:0] in_dst_ptr;
  logic        ret_valid, flush, stall_in;
  logic [5:0]  ret_ptr;
  logic [2:0]  out_valid;
  logic [20:0] out_psrc0, out_psrc1;
  logic        out_partial_stall;

  always #2.5 clk = ~clk;

  rat_rename u_dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  bit       m_rrf [8];
  bit       m_nar [8];
  int       m_ptr [8];
  logic [2:0] e_valid;
  logic [6:0] e_ps [3][2];
  logic       e_pst;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = 0; in_dst_valid = 0; in_dst_narrow = 0;
    in_src0 = 0; in_src1 = 0; in_dst = 0; in_wide = 0; in_dst_ptr = 0;
    ret_valid = 0; ret_ptr = 0; flush = 0; stall_in = 0;
  endtask

  task automatic set_op(int i, int s0, int s1, bit w0, bit w1, bit dv, int d, bit nar, int dp);
    in_valid[i] = 1;
    in_src0[i*3 +: 3] = s0[2:0];
    in_src1[i*3 +: 3] = s1[2:0];
    in_wide[i*2] = w0;
    in_wide[i*2+1] = w1;
    in_dst_valid[i] = dv;
    in_dst[i*3 +: 3] = d[2:0];
    in_dst_narrow[i] = nar;
    in_dst_ptr[i*6 +: 6] = dp[5:0];
  endtask

  task automatic run_cycle(string req);
    logic [6:0] ps_new [3][2];
    bit pst = 0;
    for (int i = 0; i < 3; i++) begin
      for (int s = 0; s < 2; s++) begin
        int lr = (s == 0) ? int'(in_src0[i*3 +: 3]) : int'(in_src1[i*3 +: 3]);
        bit c = m_rrf[lr];
        int p = m_ptr[lr];
        bit n = m_nar[lr] && !m_rrf[lr];
        for (int j = 0; j < i; j++)
          if (in_valid[j] && in_dst_valid[j] && int'(in_dst[j*3 +: 3]) == lr) begin
            c = 0; p = int'(in_dst_ptr[j*6 +: 6]); n = in_dst_narrow[j];
          end
        ps_new[i][s] = c ? 7'h40 : {1'b0, 6'(p)};
        if (in_valid[i] && in_wide[i*2+s] && n) pst = 1;
      end
    end
    @(posedge clk);
    if (flush) begin
      for (int r = 0; r < 8; r++) begin m_rrf[r] = 1; m_nar[r] = 0; end
    end else begin
      if (ret_valid)
        for (int r = 0; r < 8; r++)
          if (!m_rrf[r] && m_ptr[r] == int'(ret_ptr)) begin m_rrf[r] = 1; m_nar[r] = 0; end
      if (!stall_in)
        for (int i = 0; i < 3; i++)
          if (in_valid[i] && in_dst_valid[i]) begin
            m_rrf[in_dst[i*3 +: 3]] = 0;
            m_ptr[in_dst[i*3 +: 3]] = int'(in_dst_ptr[i*6 +: 6]);
            m_nar[in_dst[i*3 +: 3]] = in_dst_narrow[i];
          end
    end
    e_valid = (flush || stall_in) ? 3'b000 : in_valid;
    e_pst   = (flush || stall_in) ? 1'b0 : pst;
    e_ps    = ps_new;
    @(negedge clk);
    check(req, "out_valid", 32'(out_valid), 32'(e_valid));
    check(req, "partial_stall", 32'(out_partial_stall), 32'(e_pst));
    for (int i = 0; i < 3; i++)
      if (e_valid[i]) begin
        check(req, "psrc0", 32'(out_psrc0[i*7 +: 7]), 32'(e_ps[i][0]));
        check(req, "psrc1", 32'(out_psrc1[i*7 +: 7]), 32'(e_ps[i][1]));
      end
    clear_in();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    clear_in();
    for (int r = 0; r < 8; r++) begin m_rrf[r] = 1; m_nar[r] = 0; m_ptr[r] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R9", "reset valid", 32'(out_valid), 0);
    check("R9", "reset psrc0", 32'(out_psrc0), 0);
    check("R9", "reset pstall", 32'(out_partial_stall), 0);
    set_op(0, 0, 7, 1, 1, 0, 0, 0, 0);
    run_cycle("R9");
    check("R9", "committed after reset", 32'(out_psrc1[6:0]), 32'h40);

    set_op(0, 0, 0, 0, 0, 1, 3, 0, 5);
    run_cycle("R1");
    set_op(0, 3, 4, 0, 0, 0, 0, 0, 0);
    run_cycle("R2");
    check("R2", "mapped source", 32'(out_psrc0[6:0]), 32'h05);
    check("R2", "committed source", 32'(out_psrc1[6:0]), 32'h40);

    set_op(0, 0, 0, 0, 0, 1, 2, 0, 7);
    set_op(1, 2, 0, 0, 0, 1, 2, 0, 9);
    set_op(2, 2, 3, 0, 0, 1, 2, 0, 8);
    run_cycle("R3");
    check("R3", "op1 override", 32'(out_psrc0[13:7]), 32'h07);
    check("R3", "op2 nearest writer", 32'(out_psrc0[20:14]), 32'h09);
    check("R3", "op2 table read", 32'(out_psrc1[20:14]), 32'h05);

    set_op(0, 2, 0, 0, 0, 0, 0, 0, 0);
    run_cycle("R4");
    check("R4", "youngest kept", 32'(out_psrc0[6:0]), 32'h08);

    ret_valid = 1; ret_ptr = 7; set_op(0, 2, 0, 0, 0, 0, 0, 0, 0);
    run_cycle("R5");
    ret_valid = 1; ret_ptr = 8; set_op(0, 2, 0, 0, 0, 0, 0, 0, 0);
    run_cycle("R5");
    check("R5", "stale retire ignored", 32'(out_psrc0[6:0]), 32'h08);
    set_op(0, 2, 0, 0, 0, 0, 0, 0, 0);
    run_cycle("R5");
    check("R5", "matching retire commits", 32'(out_psrc0[6:0]), 32'h40);
    ret_valid = 1; ret_ptr = 5; set_op(0, 0, 0, 0, 0, 1, 3, 0, 12);
    run_cycle("R5");
    set_op(0, 3, 0, 0, 0, 0, 0, 0, 0);
    run_cycle("R5");
    check("R5", "rename beats retire", 32'(out_psrc0[6:0]), 32'h0c);

    set_op(0, 0, 0, 0, 0, 1, 4, 0, 13);
    run_cycle("R6");
    flush = 1; set_op(0, 0, 0, 0, 0, 1, 5, 0, 14);
    run_cycle("R6");
    check("R6", "flush drops group", 32'(out_valid), 0);
    set_op(0, 4, 5, 0, 0, 0, 0, 0, 0);
    run_cycle("R6");
    check("R6", "flushed r4", 32'(out_psrc0[6:0]), 32'h40);
    check("R6", "dropped r5 write", 32'(out_psrc1[6:0]), 32'h40);

    set_op(0, 0, 0, 0, 0, 1, 6, 0, 15);
    run_cycle("R7");
    stall_in = 1; ret_valid = 1; ret_ptr = 15; set_op(0, 0, 0, 0, 0, 1, 6, 0, 16);
    run_cycle("R7");
    check("R7", "stall suppresses valid", 32'(out_valid), 0);
    set_op(0, 6, 0, 0, 0, 0, 0, 0, 0);
    run_cycle("R7");
    check("R7", "retire during stall", 32'(out_psrc0[6:0]), 32'h40);

    set_op(0, 0, 0, 0, 0, 1, 1, 1, 17);
    run_cycle("R8");
    set_op(0, 1, 0, 1, 0, 0, 0, 0, 0);
    run_cycle("R8");
    check("R8", "wide after narrow", 32'(out_partial_stall), 1);
    set_op(0, 1, 0, 0, 0, 0, 0, 0, 0);
    run_cycle("R8");
    check("R8", "narrow read no stall", 32'(out_partial_stall), 0);
    set_op(0, 0, 0, 0, 0, 1, 7, 1, 18);
    set_op(1, 7, 0, 1, 0, 0, 0, 0, 0);
    run_cycle("R8");
    check("R8", "in-group narrow", 32'(out_partial_stall), 1);
    ret_valid = 1; ret_ptr = 18;
    run_cycle("R8");
    set_op(0, 7, 0, 1, 0, 0, 0, 0, 0);
    run_cycle("R8");
    check("R8", "retired narrow clears", 32'(out_partial_stall), 0);

    set_op(0, 0, 0, 0, 0, 1, 0, 0, 19);
    set_op(1, 0, 0, 0, 0, 0, 0, 0, 0);
    in_valid[0] = 0;
    run_cycle("R10");
    check("R10", "no override from invalid", 32'(out_psrc0[13:7]), 32'h40);
    set_op(0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_op(1, 1, 0, 1, 0, 0, 0, 0, 0);
    in_valid[1] = 0;
    run_cycle("R10");
    check("R10", "no table write from invalid", 32'(out_psrc0[6:0]), 32'h40);
    check("R10", "no stall from invalid", 32'(out_partial_stall), 0);

    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 3; i++) begin
        if ($urandom_range(0, 3) != 0)
          set_op(i, $urandom_range(0, 7), $urandom_range(0, 7), 1'($urandom),
                 1'($urandom), 1'($urandom), $urandom_range(0, 7), 1'($urandom),
                 $urandom_range(0, 39));
      end
      ret_valid = 1'($urandom);
      ret_ptr = 6'($urandom_range(0, 39));
      flush = ($urandom_range(0, 60) == 0);
      stall_in = ($urandom_range(0, 15) == 0);
      run_cycle("R1");
    end

    finish_run();
  end
endmodule